// File: doc/BRIEF.md
# Symmetric Up-Down PWM Generator

The block produces two pulse-width-modulated outputs from one shared timebase. A 16-bit counter climbs from zero to a programmable top value and falls back to zero. That gives a triangle waveform whose full cycle is twice the top value in counter ticks. A clock-enable prescaler sets the tick rate, so the counter can step on every clock or on every Nth clock.

Six counter events can drive each output: zero, top, compare A met while rising, compare A met while falling, compare B met while rising, and compare B met while falling. Each output has its own table of actions. For each event the action is one of: nothing, drive low, drive high, or invert. Software writes the compare thresholds into holding registers. The active thresholds take the new values only at a zero event, so a change never tears a cycle in progress.

An event trigger raises a sticky interrupt flag on a selected event. It can skip events, firing on every first, second, third or fourth one. A separate output gives a one-clock pulse at each zero event, for synchronising other timers.

Top module: `pwm_updown_gen`

## Requirements
- R1: After reset, with `period` = P > 0 and ticks on every clock, `counter` steps 1, 2, … P, P−1, … 0, 1, … on successive clocks. `count_down` becomes 1 on the clock after the counter shows P and becomes 0 on the clock after it shows 0. One output cycle therefore lasts 2·P ticks.
- R2: A tick occurs once every `clk_div`+1 clocks. With `clk_div` = 0 the counter steps on every clock. Counter and outputs change only on ticks.
- R3: Each action field is 2 bits: 0 = none, 1 = drive low, 2 = drive high, 3 = invert. In `act_a` and `act_b` the fields sit at these bits: [1:0] zero, [3:2] top (counter = P), [5:4] compare A rising, [7:6] compare A falling, [9:8] compare B rising, [11:10] compare B falling. An output changes on the clock after the tick that carries its event.
- R4: A compare event counts as rising when `count_down` is 0 and as falling when it is 1. This lets a rising-set / falling-clear pair form a pulse of 2·(P−C) ticks centred on the top.
- R5: When several events carry a non-none action in the same tick, only one action applies. Order of precedence: zero, top, compare B falling, compare B rising, compare A falling, compare A rising.
- R6: A pulse on `cmpa_wr` or `cmpb_wr` stores the data in a holding register. The active threshold takes the held value only at a zero event.
- R7: `int_sel` chooses the interrupt source: 0 = zero, 1 = top, 2 = compare A rising, 3 = compare B falling. The source counts only while `int_en` = 1. `irq_flag` sets on the clock after the qualifying event and stays set until an `int_clr` pulse. If a set and a clear fall in the same clock, the set wins.
- R8: `irq_flag` sets on every (`int_every`+1)th qualifying event.
- R9: `sync_out` is high for exactly one clock after each zero event, and is low at all other times.
- R10: While `period` is 0, the counter is held at 0 on the next clock regardless of ticks, and no top event or top interrupt occurs.
- R11: While `rst` is high, `counter`, `count_down`, `pwm_a`, `pwm_b`, `sync_out` and `irq_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 3 | Tick divider, tick every clk_div+1 clocks |
| period | input | 16 | Counter top value P |
| cmpa_wr | input | 1 | Write strobe for the compare A holding register |
| cmpa_data | input | 16 | Compare A value to hold |
| cmpb_wr | input | 1 | Write strobe for the compare B holding register |
| cmpb_data | input | 16 | Compare B value to hold |
| act_a | input | 12 | Event action table for output A |
| act_b | input | 12 | Event action table for output B |
| int_sel | input | 2 | Interrupt source select |
| int_en | input | 1 | Interrupt source enable |
| int_every | input | 2 | Interrupt event skip count |
| int_clr | input | 1 | Clear pulse for irq_flag |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| sync_out | output | 1 | One-clock pulse per zero event |
| irq_flag | output | 1 | Sticky interrupt flag |
| counter | output | 16 | Current counter value |
| count_down | output | 1 | Counter direction, 1 while falling |

## Verification
Two pairs of events can land in the same tick. A compare at 0 coincides with the zero event. A compare equal to P coincides with the top event. One test vector sets compare A to 0 with a falling-clear action against a zero-set action. It also sets compare B to P with a rising-set action against a top-clear action. The measured high time must then equal P. If a compare action won either contest, that output would stay stuck and the measurement would time out. A second pairing covers a compare write landing mid-cycle. The bench checks that the counter value at the next rising edge of the output still reflects the old threshold, and only the following cycle reflects the new one.

// File: rtl/pwm_updown_pkg.sv
package pwm_updown_pkg;

    localparam int EVT_N = 6;
    localparam int ACT_W = 2 * EVT_N;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_INV  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ISEL_ZERO = 2'd0,
        ISEL_TOP  = 2'd1,
        ISEL_CAR  = 2'd2,
        ISEL_CBF  = 2'd3
    } isel_e;

    // bit 0 is zero, bit 5 is compare B falling
    typedef struct packed {
        logic cb_fall;
        logic cb_rise;
        logic ca_fall;
        logic ca_rise;
        logic top;
        logic zero;
    } evt_t;

    // R5: later tests override earlier ones, so zero ends highest
    function automatic act_e pick_action(input evt_t ev, input logic [ACT_W-1:0] cfg);
        act_e r;
        r = ACT_NONE;
        if (ev.ca_rise && cfg[5:4]   != 2'd0) r = act_e'(cfg[5:4]);
        if (ev.ca_fall && cfg[7:6]   != 2'd0) r = act_e'(cfg[7:6]);
        if (ev.cb_rise && cfg[9:8]   != 2'd0) r = act_e'(cfg[9:8]);
        if (ev.cb_fall && cfg[11:10] != 2'd0) r = act_e'(cfg[11:10]);
        if (ev.top     && cfg[3:2]   != 2'd0) r = act_e'(cfg[3:2]);
        if (ev.zero    && cfg[1:0]   != 2'd0) r = act_e'(cfg[1:0]);
        return r;
    endfunction

    function automatic logic apply_action(input logic cur, input act_e a);
        logic n;
        case (a)
            ACT_LOW:  n = 1'b0;
            ACT_HIGH: n = 1'b1;
            ACT_INV:  n = ~cur;
            default:  n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_updown_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    output logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output evt_t             ev
);

    logic [DIV_W-1:0] pre_q;
    logic             prd_zero;

    assign tick     = (pre_q >= div);
    assign prd_zero = (period == '0);

    always_ff @(posedge clk) begin
        if (rst || tick) pre_q <= '0;
        else             pre_q <= pre_q + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || prd_zero) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else if (tick) begin
            if (!dir_down) begin
                if (cnt >= period) begin
                    dir_down <= 1'b1;
                    cnt      <= cnt - CNT_W'(1);
                end else begin
                    cnt      <= cnt + CNT_W'(1);
                end
            end else begin
                if (cnt == '0) begin
                    dir_down <= 1'b0;
                    cnt      <= CNT_W'(1);
                end else begin
                    cnt      <= cnt - CNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        ev.zero    = tick && (cnt == '0);
        ev.top     = tick && !prd_zero && (cnt == period);
        ev.ca_rise = tick && !dir_down && (cnt == cmpa);
        ev.ca_fall = tick &&  dir_down && (cnt == cmpa);
        ev.cb_rise = tick && !dir_down && (cnt == cmpb);
        ev.cb_fall = tick &&  dir_down && (cnt == cmpb);
    end

endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] data,
    input  logic             load,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            active <= '0;
        end else begin
            if (wr)   hold_q <= data;
            if (load) active <= hold_q;
        end
    end

endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
    import pwm_updown_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             ev,
    input  logic [ACT_W-1:0] cfg,
    output logic             out_q
);

    act_e act;

    always_comb act = pick_action(ev, cfg);

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= apply_action(out_q, act);
    end

endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
    import pwm_updown_pkg::*;
#(
    parameter int EVP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             ev,
    input  logic [1:0]       sel,
    input  logic             en,
    input  logic [EVP_W-1:0] every,
    input  logic             clr,
    output logic             sync_out,
    output logic             irq_flag
);

    logic [EVP_W-1:0] evc_q;
    logic             src;
    logic             hit;
    logic             fire;

    always_comb begin
        case (isel_e'(sel))
            ISEL_ZERO: src = ev.zero;
            ISEL_TOP:  src = ev.top;
            ISEL_CAR:  src = ev.ca_rise;
            default:   src = ev.cb_fall;
        endcase
        hit  = en && src;
        fire = hit && (evc_q >= every);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evc_q    <= '0;
            irq_flag <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            sync_out <= ev.zero;
            if (fire)     evc_q <= '0;
            else if (hit) evc_q <= evc_q + EVP_W'(1);
            if (fire)     irq_flag <= 1'b1;
            else if (clr) irq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_updown_gen.sv
module pwm_updown_gen
    import pwm_updown_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 3,
    parameter int EVP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [CNT_W-1:0] period,
    input  logic             cmpa_wr,
    input  logic [CNT_W-1:0] cmpa_data,
    input  logic             cmpb_wr,
    input  logic [CNT_W-1:0] cmpb_data,
    input  logic [11:0]      act_a,
    input  logic [11:0]      act_b,
    input  logic [1:0]       int_sel,
    input  logic             int_en,
    input  logic [EVP_W-1:0] int_every,
    input  logic             int_clr,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             sync_out,
    output logic             irq_flag,
    output logic [CNT_W-1:0] counter,
    output logic             count_down
);

    localparam int CH_N = 2;

    logic             tick;
    evt_t             ev;
    logic [CH_N-1:0]  cmp_wr;
    logic [CNT_W-1:0] cmp_in  [CH_N];
    logic [CNT_W-1:0] cmp_act [CH_N];
    logic [ACT_W-1:0] act_cfg [CH_N];
    logic [CH_N-1:0]  pwm_v;

    assign cmp_wr     = {cmpb_wr, cmpa_wr};
    assign cmp_in[0]  = cmpa_data;
    assign cmp_in[1]  = cmpb_data;
    assign act_cfg[0] = act_a;
    assign act_cfg[1] = act_b;

    pwm_tb_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .div      (clk_div),
        .period   (period),
        .cmpa     (cmp_act[0]),
        .cmpb     (cmp_act[1]),
        .tick     (tick),
        .cnt      (counter),
        .dir_down (count_down),
        .ev       (ev)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        pwm_cmp_shadow #(.CNT_W(CNT_W)) u_shd (
            .clk    (clk),
            .rst    (rst),
            .wr     (cmp_wr[g]),
            .data   (cmp_in[g]),
            .load   (ev.zero),
            .active (cmp_act[g])
        );
        pwm_aq u_aq (
            .clk   (clk),
            .rst   (rst),
            .ev    (ev),
            .cfg   (act_cfg[g]),
            .out_q (pwm_v[g])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

    pwm_evt_trig #(.EVP_W(EVP_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sel      (int_sel),
        .en       (int_en),
        .every    (int_every),
        .clr      (int_clr),
        .sync_out (sync_out),
        .irq_flag (irq_flag)
    );

endmodule

// File: rtl/pwm_updown_chk.sv
module pwm_updown_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] counter,
    input logic             sync_out,
    input logic             irq_flag,
    input logic             int_en,
    input logic             int_clr,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             tick
);

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (period != '0 && $stable(period)) |->
            (counter == $past(counter) ||
             counter == $past(counter) + CNT_W'(1) ||
             counter == $past(counter) - CNT_W'(1)));

    a_r2_pwm_a_tick: assert property (@(posedge clk) disable iff (rst)
        (pwm_a != $past(pwm_a)) |-> $past(tick));

    a_r2_pwm_b_tick: assert property (@(posedge clk) disable iff (rst)
        (pwm_b != $past(pwm_b)) |-> $past(tick));

    a_r9_sync_at_zero: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> ($past(counter) == '0));

    a_r10_zero_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(period) == '0) |-> (counter == '0));

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_flag) && !$past(int_clr)) |-> irq_flag);

    a_r7_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(int_en));

endmodule

bind pwm_updown_gen pwm_updown_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .period   (period),
    .counter  (counter),
    .sync_out (sync_out),
    .irq_flag (irq_flag),
    .int_en   (int_en),
    .int_clr  (int_clr),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b),
    .tick     (tick)
);

// File: tb/pwm_updown_gen_bench.sv
`timescale 1ns/100ps
module pwm_updown_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  clk_div = '0;
    logic [15:0] period = 16'd3;
    logic        cmpa_wr = 1'b0;
    logic [15:0] cmpa_data = '0;
    logic        cmpb_wr = 1'b0;
    logic [15:0] cmpb_data = '0;
    logic [11:0] act_a = '0;
    logic [11:0] act_b = '0;
    logic [1:0]  int_sel = 2'd1;
    logic        int_en = 1'b0;
    logic [1:0]  int_every = '0;
    logic        int_clr = 1'b0;
    logic        pwm_a, pwm_b, sync_out, irq_flag, count_down;
    logic [15:0] counter;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwm_updown_gen u_pwm_updown_gen (
        .clk(clk), .rst(rst), .clk_div(clk_div), .period(period),
        .cmpa_wr(cmpa_wr), .cmpa_data(cmpa_data),
        .cmpb_wr(cmpb_wr), .cmpb_data(cmpb_data),
        .act_a(act_a), .act_b(act_b),
        .int_sel(int_sel), .int_en(int_en), .int_every(int_every), .int_clr(int_clr),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_out(sync_out), .irq_flag(irq_flag),
        .counter(counter), .count_down(count_down)
    );

    typedef struct packed {
        int prd; int div; int ca; int cb; int aa; int ab;
        int ahi; int aper; int bhi;
    } vec_t;

    localparam int NV = 5;
    localparam int LIM = 1000;
    localparam vec_t VECS [NV] = '{
        // R1 R3: zero drives high, top drives low
        '{25, 0, 0, 0, 'h006, 'h006, 25, 50, 25},
        // R2: divide by three
        '{10, 2, 0, 0, 'h006, 'h006, 30, 60, 30},
        // R4: centred pulses from rising/falling compares
        '{20, 0, 5, 15, 'h060, 'h900, 30, 40, 30},
        // R3: invert actions on zero and top
        '{8, 0, 0, 0, 'h003, 'h00C, 16, 32, 16},
        // R5: compare at 0 and at P coincide with zero and top
        '{12, 0, 0, 12, 'h046, 'h206, 12, 24, 12}
    };

    task automatic chk(input int got, input int exp, input string rq, input string what);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, got, exp);
        end
    endtask

    function automatic logic sig(input int which);
        case (which)
            0:       return pwm_a;
            1:       return pwm_b;
            default: return sync_out;
        endcase
    endfunction

    task automatic measure(input int which, output int hi, output int per);
        int t;
        hi = 0; per = 0;
        t = 0;
        while (sig(which) !== 1'b0 && t < LIM) begin @(negedge clk); t++; end
        if (t >= LIM) return;
        t = 0;
        while (sig(which) !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
        if (t >= LIM) return;
        t = 0;
        while (sig(which) === 1'b1 && t < LIM) begin @(negedge clk); t++; end
        if (t >= LIM) return;
        hi = t;
        while (sig(which) === 1'b0 && t < 2*LIM) begin @(negedge clk); t++; end
        if (t >= 2*LIM) begin hi = 0; return; end
        per = t;
    endtask

    task automatic write_cmp(input int ca, input int cb);
        cmpa_data = 16'(ca); cmpb_data = 16'(cb);
        cmpa_wr = 1'b1; cmpb_wr = 1'b1;
        @(negedge clk);
        cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    endtask

    task automatic wait_cnt(input int v, input logic dn);
        int t;
        t = 0;
        while (!(counter == 16'(v) && count_down == dn) && t < LIM) begin @(negedge clk); t++; end
    endtask

    task automatic wait_level(input logic lvl);
        int t;
        t = 0;
        while (pwm_a !== lvl && t < LIM) begin @(negedge clk); t++; end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int hi, per, seen;
        int exp_cnt [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
        int exp_dn  [8] = '{0, 0, 0, 1, 1, 1, 0, 0};

        repeat (4) @(negedge clk);
        // R11: reset state
        chk(int'(counter), 0, "R11", "counter in reset");
        chk(int'({pwm_a, pwm_b, sync_out, irq_flag, count_down}), 0, "R11", "outputs in reset");
        rst = 1'b0;

        // R1: triangle sequence with P = 3
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(int'(counter), exp_cnt[i], "R1", "counter step");
            chk(int'(count_down), exp_dn[i], "R1", "direction step");
        end

        // table walk
        for (int v = 0; v < NV; v++) begin
            period  = 16'(VECS[v].prd);
            clk_div = 3'(VECS[v].div);
            act_a   = 12'(VECS[v].aa);
            act_b   = 12'(VECS[v].ab);
            write_cmp(VECS[v].ca, VECS[v].cb);
            repeat (8 * VECS[v].prd * (VECS[v].div + 1) + 20) @(negedge clk);
            measure(0, hi, per);
            chk(hi,  VECS[v].ahi,  "R3/R4/R5", $sformatf("vector %0d pwm_a high", v));
            chk(per, VECS[v].aper, "R1/R2", $sformatf("vector %0d pwm_a cycle", v));
            measure(1, hi, per);
            chk(hi,  VECS[v].bhi,  "R3/R4/R5", $sformatf("vector %0d pwm_b high", v));
        end

        // R9: sync pulse width and spacing, P = 5, divide by two
        period = 16'd5; clk_div = 3'd1; act_a = '0; act_b = '0;
        repeat (60) @(negedge clk);
        measure(2, hi, per);
        chk(hi, 1, "R9", "sync width");
        chk(per, 20, "R9", "sync spacing");

        // R6: write mid-cycle keeps old threshold until zero
        period = 16'd20; clk_div = 3'd0; act_a = 12'h060;
        write_cmp(5, 0);
        repeat (200) @(negedge clk);
        wait_cnt(2, 1'b0);
        cmpa_data = 16'd10; cmpa_wr = 1'b1;
        @(negedge clk);
        cmpa_wr = 1'b0;
        wait_level(1'b1);
        chk(int'(counter), 6, "R6", "rise with old compare");
        wait_level(1'b0);
        wait_level(1'b1);
        chk(int'(counter), 11, "R6", "rise with new compare");

        // R7: interrupt on top, P = 6
        period = 16'd6; int_sel = 2'd1; int_en = 1'b0; int_every = 2'd0;
        int_clr = 1'b1; @(negedge clk); int_clr = 1'b0;
        repeat (30) @(negedge clk);
        chk(int'(irq_flag), 0, "R7", "no flag while disabled");
        int_en = 1'b1;
        seen = 0;
        while (!irq_flag && seen < LIM) begin @(negedge clk); seen++; end
        chk(int'(counter), 5, "R7", "counter when flag rises");
        repeat (20) @(negedge clk);
        chk(int'(irq_flag), 1, "R7", "flag sticky");

        // R8: every third top event
        wait_cnt(0, 1'b1);
        int_every = 2'd2; int_clr = 1'b1;
        @(negedge clk);
        int_clr = 1'b0;
        chk(int'(irq_flag), 0, "R7", "flag cleared");
        seen = 0;
        for (int t = 0; t < LIM && !irq_flag; t++) begin
            if (counter == 16'd6) seen++;
            @(negedge clk);
        end
        chk(seen, 3, "R8", "top events before flag");

        // R10: zero period holds counter, no top interrupt
        period = 16'd0; int_every = 2'd0; int_clr = 1'b1;
        @(negedge clk);
        int_clr = 1'b0;
        seen = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (counter != 16'd0 || irq_flag) seen++;
        end
        chk(seen, 0, "R10", "cycles with nonzero counter or flag");

        done = 1;
        summary();
        $finish;
    end

endmodule